// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits on the host side of a byte-wide EDO fast-page-mode DRAM of 2M words. The host issues one read or write at a time over a valid/ready handshake, using a 21-bit word address. The controller splits that address into a row and a column, drives them in turn on a shared 12-bit address bus, and sequences the row strobe, column strobe, write enable and output enable. It keeps a row open so that later accesses to the same row need only a column cycle. It closes the row when a different row is wanted, when a refresh is owed, or before the row strobe has been low too long.

After reset the controller waits a programmable settling time and then runs a fixed number of CAS-before-RAS refreshes. It raises `init_done` and accepts requests only after that. From then on a scheduler counts refresh intervals and records up to a set number of owed refreshes. An owed refresh takes priority over host traffic. Every DRAM timing is a parameter counted in clock cycles, and the defaults suit a 100 MHz clock.

Top module: `edo_dram_ctrl`

## Requirements
- R1: A host address drives its upper 12 bits (addr[20:9]) on `dram_addr` when the row strobe falls, and its lower 9 bits (addr[8:0]) on `dram_addr[8:0]`, with `dram_addr[11:9]` zero, when the column strobe falls.
- R2: After reset, `dram_ras_n` stays high for at least `P_INIT_WAIT` cycles. Exactly `P_INIT_REFS` CAS-before-RAS refreshes then run before `init_done` rises. `req_ready` is never high while `init_done` is low. Out of reset, both strobes are high and `req_ready`, `init_done` and `rvalid` are low.
- R3: Once `init_done` is high, CAS-before-RAS refreshes occur at an average rate of one per `P_REF_PERIOD` cycles. Up to `P_REF_DEBT` owed refreshes are remembered.
- R4: In a refresh, `dram_cas_n` is already low in the cycle before `dram_ras_n` falls and is still low in the cycle after. `dram_we_n` is high when `dram_ras_n` falls.
- R5: Between any two low periods, `dram_ras_n` stays high for at least `P_TRP` cycles.
- R6: A host column strobe falls at least `P_TRCD` cycles after the row strobe fell. Every row-strobe low period lasts at least `P_TRAS` cycles.
- R7: An access to the row that is already open starts no new row activation. An access to another row causes exactly one activation.
- R8: No row-strobe low period exceeds `P_TRAS_MAX` cycles. A row left idle is closed before that limit, so the next access to it reactivates it.
- R9: An owed refresh wins over page hits. Under continuous host traffic the refresh rate of R3 still holds.
- R10: For a read, `rvalid` is a one-cycle pulse that comes exactly `P_TCAS`+1 cycles after the column strobe falls, and `rdata` then carries the byte stored at that address. For a write, `dram_we_n` is low and `dram_dq_oe` is high when the column strobe falls, and `dram_dq_out` carries the data.
- R11: Each host column strobe stays low for exactly `P_TCAS` cycles. Between column strobes it stays high for at least `P_TCP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in bits 20:9, column in bits 8:0 |
| req_wdata | input | 8 | Write data |
| rvalid | output | 1 | One-cycle pulse, read data valid |
| rdata | output | 8 | Read data |
| init_done | output | 1 | Power-up sequence finished |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
Read data is due exactly `P_TCAS`+1 cycles after the column strobe falls. A bench DRAM model latches the addressed byte at that fall, and a counter started there must read `P_TCAS`+1 in the cycle where `rvalid` is seen. Strobe spacing (precharge, row-to-column delay, minimum and maximum row-strobe width, column-strobe width) is measured in cycles by run-length counters sampled on the falling clock edge. Each counter is compared at the transition that ends its run. Page-hit behaviour is judged by the number of row activations between two completed accesses. That number is corrected for any refresh that falls in between. The refresh rate is judged by comparing the refresh count with the elapsed cycles divided by the period, within one refresh either way.

// File: rtl/edo_pkg.sv
// Shared definitions for the EDO DRAM controller.
// Assumes: one controller per DRAM device, one request in flight.
package edo_pkg;

    // Sequencer states. DRAM pin levels are decoded from these.
    typedef enum logic [3:0] {
        S_INIT = 4'd0,  // power-up wait, all strobes high
        S_IDLE = 4'd1,  // row closed, precharge already met
        S_ACT  = 4'd2,  // row strobe low, row address held
        S_OPEN = 4'd3,  // row open, waiting for a hit, a miss or a close
        S_CAS  = 4'd4,  // column strobe low
        S_CP   = 4'd5,  // column strobe precharge
        S_PRE  = 4'd6,  // row strobe precharge
        S_RC   = 4'd7,  // refresh: column strobe leads
        S_RR   = 4'd8   // refresh: row strobe low
    } seq_state_t;

    // Larger of two integers, used to size counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_phase_timer.sv
// Down-counter that measures how long a sequencer state lasts.
// A load of N makes done true in the last of the N cycles that follow the
// load edge. Assumes every loaded value is at least 1.
module edo_phase_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL - 1);
        else if (load)
            cnt <= value - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_age.sv
// Counts how many cycles the row strobe has been low, saturating at P_LIMIT.
// The count is cleared in every cycle the row strobe is high.
module edo_ras_age #(
    parameter int P_LIMIT = 10000,
    localparam int AW     = $clog2(P_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_low,
    output logic [AW-1:0] age
);
    // Count while low, saturate, clear while high.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low)
            age <= '0;
        else if (age != AW'(P_LIMIT))
            age <= age + AW'(1);
    end
endmodule

// File: rtl/edo_refresh_sched.sv
// Refresh scheduler: after enable, adds one owed refresh every P_PERIOD
// cycles and removes one for each acknowledge. Owed refreshes saturate at
// P_DEBT. Assumes ack is given only while pending is high.
module edo_refresh_sched #(
    parameter int P_PERIOD = 1560,
    parameter int P_DEBT   = 8,
    localparam int PW      = $clog2(P_PERIOD + 1),
    localparam int DW      = $clog2(P_DEBT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pending
);
    logic [PW-1:0] tick_cnt;
    logic [DW-1:0] debt;
    logic          tick;

    assign tick = en && (tick_cnt == PW'(P_PERIOD - 1));

    // Interval counter, held at zero until the power-up sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + PW'(1);
    end

    // Owed-refresh count: add on tick, remove on ack, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            debt <= '0;
        else if (tick && !ack && debt != DW'(P_DEBT))
            debt <= debt + DW'(1);
        else if (!tick && ack && debt != '0)
            debt <= debt - DW'(1);
    end

    assign pending = (debt != '0);
endmodule

// File: rtl/edo_dram_ctrl.sv
// EDO fast-page-mode DRAM controller, 2M x 8.
// Takes one host request at a time. Keeps the last row open for page hits.
// Closes it on a miss, on an owed refresh, or before the row strobe reaches
// its maximum low time. Runs the power-up wait and refresh burst first.
// Assumes: timing parameters are in clock cycles, each at least 1, and
// P_TRAS + P_TCAS + P_TCP + 4 < P_TRAS_MAX. Pin levels are decoded from the
// state register.
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int P_ROW_W     = 12,
    parameter int P_COL_W     = 9,
    parameter int P_DATA_W    = 8,
    parameter int P_INIT_WAIT = 20000,
    parameter int P_INIT_REFS = 8,
    parameter int P_REF_PERIOD = 1560,
    parameter int P_REF_DEBT  = 8,
    parameter int P_TRCD      = 2,
    parameter int P_TRP       = 4,
    parameter int P_TRAS      = 6,
    parameter int P_TCAS      = 1,
    parameter int P_TCP       = 1,
    parameter int P_TRAS_MAX  = 10000,
    localparam int AW         = P_ROW_W + P_COL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [AW-1:0]       req_addr,
    input  logic [P_DATA_W-1:0] req_wdata,
    output logic                rvalid,
    output logic [P_DATA_W-1:0] rdata,
    output logic                init_done,
    output logic [P_ROW_W-1:0]  dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [P_DATA_W-1:0] dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [P_DATA_W-1:0] dram_dq_in
);
    localparam int TW        = $clog2(imax(P_INIT_WAIT, 255) + 1);
    localparam int AGE_W     = $clog2(P_TRAS_MAX + 1);
    localparam int GUARD     = P_TCAS + P_TCP + 4;
    localparam int EXPIRE_AT = P_TRAS_MAX - GUARD;
    localparam int IW        = $clog2(P_INIT_REFS + 1);

    seq_state_t           st, nxt;
    logic                 t_load;
    logic [TW-1:0]        t_val;
    logic                 t_done;
    logic [AGE_W-1:0]     age;
    logic                 ref_pending, ref_ack;
    logic [IW-1:0]        init_left;
    logic                 init_done_q;
    logic                 have_req, q_we;
    logic [AW-1:0]        q_addr;
    logic [P_DATA_W-1:0]  q_wdata;
    logic [P_ROW_W-1:0]   open_row;
    logic                 cap_pend;
    logic                 need_ref, expire, ras_min_ok, row_hit, accept;
    logic                 ras_low;

    assign need_ref   = ref_pending || (init_left != '0);
    assign expire     = (age >= AGE_W'(EXPIRE_AT));
    assign ras_min_ok = (age >= AGE_W'(P_TRAS));
    assign row_hit    = (q_addr[AW-1:P_COL_W] == open_row);
    assign req_ready  = init_done_q && !have_req && !need_ref &&
                        ((st == S_IDLE) || (st == S_OPEN && !expire));
    assign accept     = req_valid && req_ready;
    assign ref_ack    = (st == S_RC) && t_done && (init_left == '0);
    assign init_done  = init_done_q;

    // State timer: one counter shared by every timed state.
    edo_phase_timer #(.W(TW), .RST_VAL(P_INIT_WAIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_val), .done(t_done)
    );

    // Row-strobe age, used for the minimum width and the forced close.
    edo_ras_age #(.P_LIMIT(P_TRAS_MAX)) u_age (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .age(age)
    );

    // Periodic refresh demand, started once the power-up burst is over.
    edo_refresh_sched #(.P_PERIOD(P_REF_PERIOD), .P_DEBT(P_REF_DEBT)) u_ref (
        .clk(clk), .rst_n(rst_n), .en(init_done_q), .ack(ref_ack),
        .pending(ref_pending)
    );

    // Next-state logic and timer reload for the state being entered.
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = TW'(1);
        case (st)
            S_INIT: if (t_done) nxt = S_IDLE;
            S_IDLE: begin
                if (need_ref) begin
                    nxt = S_RC; t_load = 1'b1; t_val = TW'(1);
                end else if (have_req) begin
                    nxt = S_ACT; t_load = 1'b1; t_val = TW'(P_TRCD);
                end
            end
            S_RC: if (t_done) begin
                nxt = S_RR; t_load = 1'b1; t_val = TW'(P_TRAS);
            end
            S_RR: if (t_done) begin
                nxt = S_PRE; t_load = 1'b1; t_val = TW'(P_TRP);
            end
            S_PRE: if (t_done) nxt = S_IDLE;
            S_ACT: if (t_done) begin
                nxt = S_CAS; t_load = 1'b1; t_val = TW'(P_TCAS);
            end
            S_CAS: if (t_done) begin
                nxt = S_CP; t_load = 1'b1; t_val = TW'(P_TCP);
            end
            S_CP: if (t_done) nxt = S_OPEN;
            S_OPEN: begin
                if ((need_ref || expire || (have_req && !row_hit)) && ras_min_ok) begin
                    nxt = S_PRE; t_load = 1'b1; t_val = TW'(P_TRP);
                end else if (have_req && row_hit) begin
                    nxt = S_CAS; t_load = 1'b1; t_val = TW'(P_TCAS);
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_INIT;
        else        st <= nxt;
    end

    // Request holding register: filled on accept, emptied when its column cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_req <= 1'b0;
            q_we     <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
        end else if (accept) begin
            have_req <= 1'b1;
            q_we     <= req_we;
            q_addr   <= req_addr;
            q_wdata  <= req_wdata;
        end else if (nxt == S_CAS && st != S_CAS) begin
            have_req <= 1'b0;
        end
    end

    // Open-row tag, taken when an activation reaches its column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                            open_row <= '0;
        else if (st == S_ACT && nxt == S_CAS)  open_row <= q_addr[AW-1:P_COL_W];
    end

    // Power-up refresh countdown and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_left   <= IW'(P_INIT_REFS);
            init_done_q <= 1'b0;
        end else begin
            if (st == S_RC && t_done && init_left != '0)
                init_left <= init_left - IW'(1);
            if (st == S_IDLE && init_left == '0)
                init_done_q <= 1'b1;
        end
    end

    // Read capture, one cycle after the column strobe count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pend <= 1'b0;
            rvalid   <= 1'b0;
            rdata    <= '0;
        end else begin
            cap_pend <= (st == S_CAS) && t_done && !q_we;
            rvalid   <= cap_pend;
            if (cap_pend) rdata <= dram_dq_in;
        end
    end

    // Pin decode from the state register.
    always_comb begin
        ras_low     = (st == S_ACT) || (st == S_OPEN) || (st == S_CAS) ||
                      (st == S_CP)  || (st == S_RR);
        dram_ras_n  = !ras_low;
        dram_cas_n  = !((st == S_CAS) || (st == S_RC) || (st == S_RR));
        dram_we_n   = !((st == S_CAS) && q_we);
        dram_oe_n   = !(((st == S_CAS) || (st == S_CP)) && !q_we);
        dram_dq_oe  = (st == S_CAS) && q_we;
        dram_dq_out = q_wdata;
        if (st == S_CAS || st == S_CP)
            dram_addr = {{(P_ROW_W - P_COL_W){1'b0}}, q_addr[P_COL_W-1:0]};
        else
            dram_addr = q_addr[AW-1:P_COL_W];
    end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
// Pin-level timing checker for edo_dram_ctrl, attached by bind.
// Counts strobe run lengths itself, so large limits need no deep $past.
module edo_dram_ctrl_chk #(
    parameter int P_TRP      = 4,
    parameter int P_TRCD     = 2,
    parameter int P_TRAS_MAX = 10000,
    localparam int HW        = $clog2(P_TRP + 1),
    localparam int LW        = $clog2(P_TRAS_MAX + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic req_ready,
    input logic init_done,
    input logic rvalid
);
    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;

    // Run-length counters of the row strobe, both saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HW'(P_TRP);
            lo_cnt <= '0;
        end else if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != HW'(P_TRP)) hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != LW'(P_TRAS_MAX + 1)) lo_cnt <= lo_cnt + LW'(1);
        end
    end

    // R2
    ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);
    // R4
    cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);
    // R4
    cbr_cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n));
    // R5
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= HW'(P_TRP)));
    // R6
    ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_cnt >= LW'(P_TRCD)));
    // R8
    ras_width_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (lo_cnt < LW'(P_TRAS_MAX)));
    // R10
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .P_TRP(P_TRP), .P_TRCD(P_TRCD), .P_TRAS_MAX(P_TRAS_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .req_ready(req_ready), .init_done(init_done),
    .rvalid(rvalid)
);

// File: tb/sim_edo_dram_ctrl.sv
// Bench for edo_dram_ctrl: a behavioural EDO DRAM model, pin timing monitors,
// directed corner cases and seeded random traffic.
module sim_edo_dram_ctrl;
    localparam int P_INIT_WAIT  = 300;
    localparam int P_INIT_REFS  = 8;
    localparam int P_REF_PERIOD = 250;
    localparam int P_TRCD = 2, P_TRP = 4, P_TRAS = 6, P_TCAS = 1, P_TCP = 1;
    localparam int P_TRAS_MAX   = 90;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rvalid, init_done;
    logic [7:0]  rdata, dram_dq_out;
    logic [11:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0]  dq_in_r = '0;

    always #4 clk = ~clk;

    edo_dram_ctrl #(
        .P_INIT_WAIT(P_INIT_WAIT), .P_INIT_REFS(P_INIT_REFS),
        .P_REF_PERIOD(P_REF_PERIOD), .P_TRCD(P_TRCD), .P_TRP(P_TRP),
        .P_TRAS(P_TRAS), .P_TCAS(P_TCAS), .P_TCP(P_TCP), .P_TRAS_MAX(P_TRAS_MAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rvalid(rvalid), .rdata(rdata), .init_done(init_done),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] mem [int];
    logic [7:0] expv [int];
    logic [20:0] cur_addr = '0;
    logic [7:0]  exp_rd = '0;
    logic [11:0] act_row = '0;
    int cyc = 0, cbr = 0, init_cbr = 0, post_cbr = 0, acts = 0, host_cas = 0;
    int hi = 1000, lo = 0, cas_lo = 0, cas_hi = 1000, rd_cnt = 0, t0 = 0;
    bit p_ras = 1'b1, p_cas = 1'b1, cbr_follow = 1'b0, host_pulse = 1'b0;
    bit rd_armed = 1'b0, rd_seen = 1'b0;
    int v_r1 = 0, v_r2 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0, v_r10 = 0, v_r11 = 0;

    // Count one check; report a mismatch with its requirement.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Print the summary line once and stop.
    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // DRAM model and pin timing monitors, sampled away from the active edge.
    always @(negedge clk) begin
        int k;
        if (rst_n) begin
            cyc++;
            if (req_ready && !init_done) v_r2++;
            if (!dram_ras_n && p_ras) begin
                if (!init_done && cyc < P_INIT_WAIT) v_r2++;
                if (hi < P_TRP) v_r5++;
                if (!dram_cas_n) begin
                    cbr++;
                    if (init_done) post_cbr++; else init_cbr++;
                    if (!dram_we_n || p_cas) v_r4++;
                    cbr_follow = 1'b1;
                end else begin
                    acts++;
                    act_row = dram_addr;
                end
            end else if (cbr_follow) begin
                if (dram_cas_n) v_r4++;
                cbr_follow = 1'b0;
            end
            if (dram_ras_n && !p_ras && lo < P_TRAS) v_r6++;
            if (!dram_ras_n) begin
                lo++; hi = 0;
                if (lo > P_TRAS_MAX) v_r8++;
            end else begin
                hi++; lo = 0;
            end
            if (!dram_cas_n && p_cas && !dram_ras_n) begin
                host_cas++;
                host_pulse = 1'b1;
                if (lo - 1 < P_TRCD) v_r6++;
                if (cas_hi < P_TCP) v_r11++;
                if ({act_row, dram_addr[8:0]} != cur_addr || dram_addr[11:9] != 3'd0) v_r1++;
                k = int'({act_row, dram_addr[8:0]});
                if (!dram_we_n) begin
                    if (!dram_dq_oe) v_r10++;
                    mem[k] = dram_dq_out;
                end else begin
                    dq_in_r  = mem.exists(k) ? mem[k] : 8'h00;
                    rd_armed = 1'b1;
                    rd_cnt   = 0;
                end
            end else if (rd_armed) begin
                rd_cnt++;
            end
            if (dram_cas_n && !p_cas && host_pulse) begin
                if (cas_lo != P_TCAS) v_r11++;
                host_pulse = 1'b0;
            end
            if (!dram_cas_n) begin cas_lo++; cas_hi = 0; end
            else begin cas_hi++; cas_lo = 0; end
            if (rvalid) begin
                chk("R10 read pending at rvalid", int'(rd_armed), 1);
                chk("R10 rvalid latency", rd_cnt, P_TCAS + 1);
                chk("R10 read data", int'(rdata), int'(exp_rd));
                rd_armed = 1'b0;
                rd_seen  = 1'b1;
            end
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
        end
    end

    // Issue one host access and wait until it has completed at the pins.
    task automatic host_op(input bit we, input logic [20:0] a, input logic [7:0] d);
        int c0;
        c0 = host_cas;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        cur_addr = a; rd_seen = 1'b0;
        if (we) expv[int'(a)] = d;
        else exp_rd = expv.exists(int'(a)) ? expv[int'(a)] : 8'h00;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (host_cas == c0) @(negedge clk);
        if (!we) while (!rd_seen) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        int a0, c0, a1, c1;
        logic [11:0] rows [4];
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        // R2 reset state
        chk("R2 ras_n in reset", int'(dram_ras_n), 1);
        chk("R2 cas_n in reset", int'(dram_cas_n), 1);
        chk("R2 ready in reset", int'(req_ready), 0);
        chk("R2 init_done in reset", int'(init_done), 0);
        chk("R2 rvalid in reset", int'(rvalid), 0);
        rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        t0 = cyc;
        chk("R2 power-up refresh count", init_cbr, P_INIT_REFS);
        chk("R2 init length at least wait", int'(cyc >= P_INIT_WAIT), 1);

        // R1 R10 extreme addresses
        host_op(1'b1, 21'h000000, 8'hA5);
        host_op(1'b1, 21'h1FFFFF, 8'h5A);
        host_op(1'b0, 21'h000000, 8'h00);
        host_op(1'b0, 21'h1FFFFF, 8'h00);

        // R7 page hit: same row, no new activation unless a refresh closed it
        host_op(1'b1, {12'h123, 9'h010}, 8'h11);
        a0 = acts; c0 = cbr;
        host_op(1'b1, {12'h123, 9'h1F0}, 8'h22);
        a1 = acts; c1 = cbr;
        chk("R7 activations on page hit", a1 - a0, (c1 != c0) ? 1 : 0);
        // R7 page miss: exactly one activation
        a0 = acts;
        host_op(1'b0, {12'h456, 9'h010}, 8'h00);
        chk("R7 activations on page miss", acts - a0, 1);

        // R8 idle open row is closed before the maximum width
        repeat (3 * P_TRAS_MAX) @(negedge clk);
        a0 = acts;
        host_op(1'b0, {12'h456, 9'h011}, 8'h00);
        chk("R8 reactivation after idle close", acts - a0, 1);

        // Random traffic on a few rows to mix hits, misses and refreshes
        rows[0] = 12'h000; rows[1] = 12'hFFF; rows[2] = 12'h123; rows[3] = 12'h800;
        for (int i = 0; i < 700; i++) begin
            logic [20:0] a;
            a = {rows[$urandom_range(3)], 9'($urandom_range(511))};
            if (($urandom_range(9) < 3) && i > 20)
                a = {rows[$urandom_range(3)], 9'($urandom_range(7))};
            host_op(($urandom_range(1) == 1), a, 8'($urandom_range(255)));
        end
        repeat (20) @(negedge clk);

        // R3 R9 refresh rate under traffic
        chk("R3 R9 refresh rate low bound", int'(post_cbr >= (cyc - t0) / P_REF_PERIOD - 1), 1);
        chk("R3 R9 refresh rate high bound", int'(post_cbr <= (cyc - t0) / P_REF_PERIOD + 1), 1);
        chk("R1 address multiplex violations", v_r1, 0);
        chk("R2 init ordering violations", v_r2, 0);
        chk("R4 refresh strobe order violations", v_r4, 0);
        chk("R5 precharge violations", v_r5, 0);
        chk("R6 row-to-column and width violations", v_r6, 0);
        chk("R8 maximum row width violations", v_r8, 0);
        chk("R10 write pin violations", v_r10, 0);
        chk("R11 column strobe width violations", v_r11, 0);
        finish_run();
    end
endmodule